// File: doc/BRIEF.md
# Processor Power State Sequencer

This block moves a processor core between four power states: full power, doze, nap and sleep. Software asks for a low-power state by setting a global power-management enable and one of three mode bits, then pulsing an entry request. The block drives registered enables for the core's functional units, its bus snoop logic and its timer unit. It also drives a PLL hold output. A wake event brings the core back to full power.

Each low-power state keeps a different set of units powered and accepts a different set of wake sources. Doze and nap wake a fixed number of cycles after a qualifying event. Sleep lets outside logic stop the PLL. A wake from sleep is only accepted once the PLL lock input is high again. While the core runs at full power, optional dynamic gating turns off the enable of each functional unit that reports itself idle.

Top module: `pwr_state_seq`

## Requirements
- R1: After synchronous reset, `state_o` is 2'b00 (full power), every bit of `unit_en` is 1, and `snoop_en`, `timer_en` and `pll_hold` are 1.
- R2: `state_o` is encoded as 2'b00 full, 2'b01 doze, 2'b10 nap and 2'b11 sleep. In full power, an `enter_req` pulse with `pm_en`=1 changes `state_o` on that same clock edge. The target is chosen by priority: sleep bit first, then nap, then doze.
- R3: `enter_req` has no effect when `pm_en`=0, when no mode bit is set, or when the state is not full power.
- R4: In doze, `unit_en` is all zeros, while `snoop_en`, `timer_en` and `pll_hold` are 1.
- R5: In nap, `unit_en` is all zeros and `snoop_en` is 0, while `timer_en` and `pll_hold` are 1.
- R6: In sleep, `unit_en`, `snoop_en`, `timer_en` and `pll_hold` are all 0.
- R7: In doze or nap, a high on `ext_irq`, `sys_mgmt_irq`, `dec_irq` or `mach_chk` at a clock edge starts the wake. `state_o` returns to 2'b00 exactly WAKE_CYC (4) edges later and stays unchanged before that.
- R8: In sleep, `dec_irq` never wakes the core. The other wake events are ignored while `pll_lock`=0. With `pll_lock`=1, they wake the core after WAKE_CYC edges, as in R7.
- R9: `hard_rst_req` or `soft_rst_req` forces `state_o` to 2'b00 on the next edge from any state. This also holds in the middle of a wake countdown.
- R10: In full power, the wake events have no effect: the state and all enables stay as they were.
- R11: In full power with `dpm_en`=1, `unit_en[i]` equals the `unit_busy[i]` value sampled at the previous edge. With `dpm_en`=0, `unit_en` is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_en | input | 1 | Global power-management enable |
| mode_doze | input | 1 | Doze mode select bit |
| mode_nap | input | 1 | Nap mode select bit |
| mode_sleep | input | 1 | Sleep mode select bit |
| enter_req | input | 1 | Pulse requesting entry into the selected mode |
| dpm_en | input | 1 | Dynamic per-unit idle gating enable |
| unit_busy | input | NUM_UNITS | Per-unit busy flags |
| ext_irq | input | 1 | External asynchronous interrupt |
| sys_mgmt_irq | input | 1 | System management interrupt |
| dec_irq | input | 1 | Decrementer exception |
| mach_chk | input | 1 | Machine check |
| hard_rst_req | input | 1 | Hard reset request |
| soft_rst_req | input | 1 | Soft reset request |
| pll_lock | input | 1 | PLL lock indicator |
| state_o | output | 2 | Current power state |
| unit_en | output | NUM_UNITS | Functional unit enables |
| snoop_en | output | 1 | Bus snoop logic enable |
| timer_en | output | 1 | Timer unit enable |
| pll_hold | output | 1 | 1 = PLL must stay powered |

## Verification
An entry request and a reset request each change `state_o` and the enables on the edge that samples them. The bench therefore checks one edge later, on the following falling edge. A wake from doze, nap or locked sleep is due on the fourth edge after the edge that samples the event. The bench checks that the state has not changed after three edges and that it reads full power after the fourth. Dynamic gating follows the busy flags with one edge of delay. All inputs change on falling edges, and all outputs are sampled on falling edges.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  typedef enum logic [1:0] {
    PS_FULL  = 2'b00,
    PS_DOZE  = 2'b01,
    PS_NAP   = 2'b10,
    PS_SLEEP = 2'b11
  } pwr_state_e;

  // Deepest requested mode wins: sleep, then nap, then doze.
  function automatic pwr_state_e pick_target(input logic d, input logic n, input logic s);
    if (s)      return PS_SLEEP;
    else if (n) return PS_NAP;
    else if (d) return PS_DOZE;
    else        return PS_FULL;
  endfunction
endpackage

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
  import pwr_seq_pkg::*;
(
  input  pwr_state_e state,
  input  logic       ext_irq,
  input  logic       sys_mgmt_irq,
  input  logic       dec_irq,
  input  logic       mach_chk,
  input  logic       pll_lock,
  output logic       wake_ok
);
  logic common_src;
  assign common_src = ext_irq | sys_mgmt_irq | mach_chk;

  always_comb begin
    unique case (state)
      PS_DOZE, PS_NAP: wake_ok = common_src | dec_irq;
      PS_SLEEP:        wake_ok = common_src & pll_lock;
      default:         wake_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/pwr_state_fsm.sv
module pwr_state_fsm
  import pwr_seq_pkg::*;
#(
  parameter int WAKE_CYC = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pm_en,
  input  logic       mode_doze,
  input  logic       mode_nap,
  input  logic       mode_sleep,
  input  logic       enter_req,
  input  logic       force_full,
  input  logic       wake_ok,
  output pwr_state_e state_q,
  output pwr_state_e state_nxt,
  output logic       waking_o
);
  localparam int CNT_W = (WAKE_CYC > 2) ? $clog2(WAKE_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WAKE_CYC - 1);

  logic             waking_q, waking_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic             any_mode;

  assign any_mode = mode_doze | mode_nap | mode_sleep;

  always_comb begin
    state_nxt  = state_q;
    waking_nxt = waking_q;
    cnt_nxt    = cnt_q;
    if (force_full) begin
      state_nxt  = PS_FULL;
      waking_nxt = 1'b0;
      cnt_nxt    = '0;
    end else if (waking_q) begin
      if (cnt_q == '0) begin
        state_nxt  = PS_FULL;
        waking_nxt = 1'b0;
      end else begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end else if (state_q == PS_FULL) begin
      if (enter_req && pm_en && any_mode)
        state_nxt = pick_target(mode_doze, mode_nap, mode_sleep);
    end else if (wake_ok) begin
      waking_nxt = 1'b1;
      cnt_nxt    = CNT_LOAD;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_FULL;
      waking_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      state_q  <= state_nxt;
      waking_q <= waking_nxt;
      cnt_q    <= cnt_nxt;
    end
  end

  assign waking_o = waking_q;

  // R9
  force_full_chk: assert property (@(posedge clk) disable iff (rst)
    force_full |=> state_q == PS_FULL);

  // R10
  full_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_FULL && !(enter_req && pm_en)) |=> state_q == PS_FULL);

  // R7
  wake_end_chk: assert property (@(posedge clk) disable iff (rst)
    (waking_q && cnt_q == '0) |=> state_q == PS_FULL);

  // R3
  low_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q != PS_FULL) |=> (state_q == PS_FULL || state_q == $past(state_q)));
endmodule

// File: rtl/pwr_enable_map.sv
module pwr_enable_map
  import pwr_seq_pkg::*;
#(
  parameter int NUM_UNITS = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  pwr_state_e           state_nxt,
  input  logic                 dpm_en,
  input  logic [NUM_UNITS-1:0] unit_busy,
  output logic [NUM_UNITS-1:0] unit_en,
  output logic                 snoop_en,
  output logic                 timer_en,
  output logic                 pll_hold
);
  logic run_full;
  assign run_full = (state_nxt == PS_FULL);

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (rst) unit_en[u] <= 1'b1;
      else     unit_en[u] <= run_full & (unit_busy[u] | ~dpm_en);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snoop_en <= 1'b1;
      timer_en <= 1'b1;
      pll_hold <= 1'b1;
    end else begin
      snoop_en <= (state_nxt == PS_FULL) || (state_nxt == PS_DOZE);
      timer_en <= (state_nxt != PS_SLEEP);
      pll_hold <= (state_nxt != PS_SLEEP);
    end
  end
endmodule

// File: rtl/pwr_state_seq.sv
module pwr_state_seq
  import pwr_seq_pkg::*;
#(
  parameter int NUM_UNITS = 4,
  parameter int WAKE_CYC  = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pm_en,
  input  logic                 mode_doze,
  input  logic                 mode_nap,
  input  logic                 mode_sleep,
  input  logic                 enter_req,
  input  logic                 dpm_en,
  input  logic [NUM_UNITS-1:0] unit_busy,
  input  logic                 ext_irq,
  input  logic                 sys_mgmt_irq,
  input  logic                 dec_irq,
  input  logic                 mach_chk,
  input  logic                 hard_rst_req,
  input  logic                 soft_rst_req,
  input  logic                 pll_lock,
  output logic [1:0]           state_o,
  output logic [NUM_UNITS-1:0] unit_en,
  output logic                 snoop_en,
  output logic                 timer_en,
  output logic                 pll_hold
);
  pwr_state_e state_q, state_nxt;
  logic       wake_ok, waking;

  pwr_wake_qual u_qual (
    .state(state_q), .ext_irq(ext_irq), .sys_mgmt_irq(sys_mgmt_irq),
    .dec_irq(dec_irq), .mach_chk(mach_chk), .pll_lock(pll_lock),
    .wake_ok(wake_ok)
  );

  pwr_state_fsm #(.WAKE_CYC(WAKE_CYC)) u_fsm (
    .clk(clk), .rst(rst), .pm_en(pm_en), .mode_doze(mode_doze),
    .mode_nap(mode_nap), .mode_sleep(mode_sleep), .enter_req(enter_req),
    .force_full(hard_rst_req | soft_rst_req), .wake_ok(wake_ok),
    .state_q(state_q), .state_nxt(state_nxt), .waking_o(waking)
  );

  pwr_enable_map #(.NUM_UNITS(NUM_UNITS)) u_map (
    .clk(clk), .rst(rst), .state_nxt(state_nxt), .dpm_en(dpm_en),
    .unit_busy(unit_busy), .unit_en(unit_en), .snoop_en(snoop_en),
    .timer_en(timer_en), .pll_hold(pll_hold)
  );

  assign state_o = state_q;

  // R4
  doze_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_DOZE) |-> (unit_en == '0 && snoop_en && timer_en && pll_hold));

  // R5
  nap_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_NAP) |-> (unit_en == '0 && !snoop_en && timer_en && pll_hold));

  // R6
  sleep_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP) |-> (unit_en == '0 && !snoop_en && !timer_en && !pll_hold));

  // R8
  sleep_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_SLEEP && !waking && !pll_lock && !hard_rst_req && !soft_rst_req)
      |=> state_q == PS_SLEEP);
endmodule

// File: tb/tb_pwr_state_seq.sv
`timescale 1ns/1ps
module tb_pwr_state_seq;
  localparam int NU = 4;
  logic clk = 0, rst = 1;
  logic pm_en = 0, mode_doze = 0, mode_nap = 0, mode_sleep = 0, enter_req = 0, dpm_en = 0;
  logic [NU-1:0] unit_busy = '0;
  logic ext_irq = 0, sys_mgmt_irq = 0, dec_irq = 0, mach_chk = 0;
  logic hard_rst_req = 0, soft_rst_req = 0, pll_lock = 0;
  logic [1:0] state_o;
  logic [NU-1:0] unit_en;
  logic snoop_en, timer_en, pll_hold;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_state_seq #(.NUM_UNITS(NU), .WAKE_CYC(4)) dut (.*);

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); @(negedge clk);
    end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Packs {unit_en, snoop, timer, pll} for one compare.
  function automatic logic [31:0] ens();
    return {25'd0, unit_en, snoop_en, timer_en, pll_hold};
  endfunction

  task automatic enter(input logic d, input logic n, input logic s);
    mode_doze = d; mode_nap = n; mode_sleep = s; enter_req = 1;
    tick();
    enter_req = 0; mode_doze = 0; mode_nap = 0; mode_sleep = 0;
  endtask

  task automatic t_reset();
    rst = 1; tick(2); rst = 0; tick();
    check("R1 state", state_o, 2'b00);
    check("R1 enables", ens(), {25'd0, 4'hF, 3'b111});
  endtask

  task automatic t_entry_ignored();
    pm_en = 0; enter(1, 0, 0);
    check("R3 pm_en off", state_o, 2'b00);
    pm_en = 1; enter(0, 0, 0);
    check("R3 no mode bit", state_o, 2'b00);
  endtask

  task automatic t_doze();
    enter(1, 0, 0);
    check("R2 doze state", state_o, 2'b01);
    check("R4 doze enables", ens(), {25'd0, 4'h0, 3'b111});
    enter(0, 1, 0);
    check("R3 entry while low", state_o, 2'b01);
    ext_irq = 1; tick(); ext_irq = 0;
    tick(3);
    check("R7 doze still waiting", state_o, 2'b01);
    tick();
    check("R7 doze woke", state_o, 2'b00);
    check("R7 full enables", ens(), {25'd0, 4'hF, 3'b111});
  endtask

  task automatic t_nap();
    enter(1, 1, 0);
    check("R2 nap priority", state_o, 2'b10);
    check("R5 nap enables", ens(), {25'd0, 4'h0, 3'b011});
    dec_irq = 1; tick(); dec_irq = 0;
    tick(3);
    check("R7 nap still waiting", state_o, 2'b10);
    tick();
    check("R7 nap woke", state_o, 2'b00);
  endtask

  task automatic t_sleep();
    pll_lock = 0;
    enter(1, 1, 1);
    check("R2 sleep priority", state_o, 2'b11);
    check("R6 sleep enables", ens(), 32'd0);
    ext_irq = 1; tick(6); ext_irq = 0;
    check("R8 no lock ignored", state_o, 2'b11);
    pll_lock = 1; dec_irq = 1; tick(6); dec_irq = 0;
    check("R8 dec ignored", state_o, 2'b11);
    sys_mgmt_irq = 1; tick(); sys_mgmt_irq = 0;
    tick(3);
    check("R8 sleep still waiting", state_o, 2'b11);
    tick();
    check("R8 sleep woke", state_o, 2'b00);
    pll_lock = 0;
  endtask

  task automatic t_reset_wake();
    enter(0, 1, 0);
    hard_rst_req = 1; tick(); hard_rst_req = 0;
    check("R9 hard from nap", state_o, 2'b00);
    enter(1, 0, 0);
    mach_chk = 1; tick(); mach_chk = 0; tick();
    soft_rst_req = 1; tick(); soft_rst_req = 0;
    check("R9 soft mid countdown", state_o, 2'b00);
    tick(3);
    check("R9 stays full", state_o, 2'b00);
    enter(0, 0, 1);
    soft_rst_req = 1; tick(); soft_rst_req = 0;
    check("R9 soft from sleep", state_o, 2'b00);
  endtask

  task automatic t_full_ignore();
    ext_irq = 1; mach_chk = 1; dec_irq = 1; sys_mgmt_irq = 1; pll_lock = 1;
    tick(3);
    ext_irq = 0; mach_chk = 0; dec_irq = 0; sys_mgmt_irq = 0; pll_lock = 0;
    check("R10 state", state_o, 2'b00);
    check("R10 enables", ens(), {25'd0, 4'hF, 3'b111});
  endtask

  task automatic t_dpm();
    dpm_en = 1; unit_busy = 4'b0101; tick();
    check("R11 gate 0101", unit_en, 4'b0101);
    unit_busy = 4'b1010; tick();
    check("R11 gate 1010", unit_en, 4'b1010);
    dpm_en = 0; tick();
    check("R11 dpm off", unit_en, 4'hF);
    unit_busy = '0;
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_entry_ignored();
    t_doze();
    t_nap();
    t_sleep();
    t_reset_wake();
    t_full_ignore();
    t_dpm();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule